// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is a byte-wide synchronous serial port with one shift register, a serial data input, a serial data output and a shift clock line. As a master it builds the shift clock from the system clock at one of four rates and drives it out. As a slave it takes the shift clock from an external pin, passes it through a two-flop synchroniser and acts on its edges in the system clock domain. Software loads a byte in parallel, sets a busy flag to start, and reads the received byte back once the flag has dropped.

The busy flag gates the shifting. Hardware drops it after a full byte. Software may drop it earlier, which leaves a short transfer with the shift clock parked low. A phase flag selects the shifting edges. In the normal phase the input is sampled on the rising edge and the register advances on the falling edge. In the alternate phase the register and the output advance on the rising edge and the input is taken on the falling edge. When the interrupt is enabled, a completed byte raises a one-cycle interrupt request.

Top module: `sio_port`

## Requirements
- R1: The control register holds enable (bit 0), master select (bit 1), rate (bits 3:2), alternate phase (bit 4) and interrupt enable (bit 5). It clears at reset, so the port comes up disabled in normal phase. It reads back what was last written.
- R2: A busy-set pulse sets busy only while enable is 1. With enable at 0 the pulse is ignored and busy stays 0.
- R3: In master mode the shift clock period is 2^(rate+1) system clock cycles (2, 4, 8 or 16), and the clock starts with a rising edge.
- R4: Hardware clears busy after exactly WIDTH shift clock cycles. The data register then holds the received byte, with the first received bit in the MSB.
- R5: In normal phase the MSB of the loaded byte is on the output before the first rising edge. The input is sampled on each rising edge, and the register and the output advance on each falling edge.
- R6: In alternate phase the output takes the next bit, MSB first, on each rising edge, and the input is captured on each falling edge.
- R7: A busy-clear pulse after k of WIDTH bits stops the transfer. The register then holds the loaded byte shifted left by k, with the k received bits in its low positions. The shift clock is low and no interrupt is raised.
- R8: When interrupt enable is 1, a completed transfer raises irq for exactly one cycle. When it is 0, or when the transfer was cut short, irq stays low.
- R9: In slave mode the port shifts on edges of sk_in using the same phase rules, and sk_out stays low.
- R10: A parallel write while the shift clock is high (the master clock, or the synchronised sk_in in slave mode) is ignored, and load_err is high in that cycle.
- R11: The shift clock output is low whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control register write value |
| ctl_rdata | output | 6 | Control register contents |
| busy_set | input | 1 | Pulse that requests a transfer start |
| busy_clr | input | 1 | Pulse that ends a transfer early |
| busy | output | 1 | Transfer in progress |
| data_we | input | 1 | Parallel load strobe for the shift register |
| data_wdata | input | WIDTH | Parallel load value |
| data_rdata | output | WIDTH | Shift register contents |
| load_err | output | 1 | Load attempted while the shift clock is high |
| irq | output | 1 | One-cycle completion interrupt request |
| sk_in | input | 1 | External shift clock (slave mode) |
| sk_out | output | 1 | Generated shift clock (master mode) |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |

## Verification
The bench builds the port with its defaults: WIDTH of 8 and a two-stage synchroniser. With these values every rate and both phases can be swept in master mode in a few hundred cycles per byte. A small partner model in the bench answers each transfer, and expected register contents are computed as shifts of the loaded and partner bytes. The byte width keeps every early-stop point from one to seven bits cheap to visit. The slave path is driven with a slow external clock so that the synchroniser delay never overlaps the next edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int RATE_W = 2;
  // Half-period counter must hold 2^(2^RATE_W - 1)
  localparam int HALF_W = 2 ** RATE_W;

  typedef struct packed {
    logic              irq_en;
    logic              alt;
    logic [RATE_W-1:0] rate;
    logic              master;
    logic              en;
  } sio_ctl_t;

  localparam int CTL_W = $bits(sio_ctl_t);

  // System clocks per shift clock half period
  function automatic logic [HALF_W-1:0] sio_half(input logic [RATE_W-1:0] r);
    return HALF_W'(1) << r;
  endfunction
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [RATE_W-1:0] rate,
  output logic              sk_q,
  output logic              rise_evt,
  output logic              fall_evt
);
  logic [HALF_W-1:0] cnt;
  logic              tick;

  assign tick     = active && (cnt == sio_half(rate) - HALF_W'(1));
  assign rise_evt = tick && !sk_q;
  assign fall_evt = tick && sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sk_q <= 1'b0;
    end else if (!active) begin
      cnt  <= '0;
      sk_q <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sk_q <= ~sk_q;
    end else begin
      cnt  <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sk_in,
  output logic level,
  output logic rise_evt,
  output logic fall_evt
);
  logic [SYNC_N:0] pipe;
  logic            prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[SYNC_N-1:0], sk_in};
  end

  assign level    = pipe[SYNC_N-1];
  assign prev     = pipe[SYNC_N];
  assign rise_evt = level && !prev;
  assign fall_evt = !level && prev;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             alt,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             si,
  output logic [WIDTH-1:0] sr,
  output logic             so,
  output logic             done_evt
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] cnt;
  logic             smp;
  logic             so_q;

  assign done_evt = fall_evt && (cnt == LAST);
  assign so       = alt ? so_q : sr[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      cnt  <= '0;
      smp  <= 1'b0;
      so_q <= 1'b0;
    end else begin
      if (load)  sr  <= load_data;
      if (start) cnt <= '0;
      if (rise_evt) begin
        if (alt) begin
          so_q <= sr[WIDTH-1];
          sr   <= sr << 1;
        end else begin
          smp  <= si;
        end
      end
      if (fall_evt) begin
        if (alt) sr[0] <= si;
        else     sr    <= {sr[WIDTH-2:0], smp};
        cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             busy_set,
  input  logic             busy_clr,
  output logic             busy,
  input  logic             data_we,
  input  logic [WIDTH-1:0] data_wdata,
  output logic [WIDTH-1:0] data_rdata,
  output logic             load_err,
  output logic             irq,
  input  logic             sk_in,
  output logic             sk_out,
  input  logic             si,
  output logic             so
);
  sio_ctl_t ctl_q;
  logic     busy_q, irq_q;
  logic     run, m_active, s_active;
  logic     m_sk, m_rise, m_fall;
  logic     s_level, s_rise, s_fall;
  logic     rise_evt, fall_evt, shift_evt, done_evt;
  logic     start_ok, sk_high, load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= sio_ctl_t'(ctl_wdata);
  end

  assign start_ok = busy_set && ctl_q.en && !busy_q;
  assign run      = busy_q && ctl_q.en && !busy_clr;
  assign m_active = run && ctl_q.master;
  assign s_active = run && !ctl_q.master;

  sio_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n), .active(m_active), .rate(ctl_q.rate),
    .sk_q(m_sk), .rise_evt(m_rise), .fall_evt(m_fall)
  );

  sio_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .sk_in(sk_in),
    .level(s_level), .rise_evt(s_rise), .fall_evt(s_fall)
  );

  assign rise_evt  = m_rise || (s_active && s_rise);
  assign fall_evt  = m_fall || (s_active && s_fall);
  assign shift_evt = rise_evt || fall_evt;
  assign sk_high   = ctl_q.master ? m_sk : s_level;
  assign load_ok   = data_we && !sk_high;

  sio_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_ok), .load(load_ok),
    .load_data(data_wdata), .alt(ctl_q.alt), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .si(si), .sr(data_rdata), .so(so),
    .done_evt(done_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (busy_clr || done_evt) busy_q <= 1'b0;
      else if (start_ok)        busy_q <= 1'b1;
      irq_q <= done_evt && ctl_q.irq_en;
    end
  end

  assign ctl_rdata = ctl_q;
  assign busy      = busy_q;
  assign irq       = irq_q;
  assign sk_out    = m_sk;
  assign load_err  = data_we && sk_high;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             busy_set,
  input logic             sk_out,
  input logic             done_evt,
  input logic             irq,
  input logic             load_err,
  input logic             shift_evt,
  input logic [WIDTH-1:0] data_rdata
);
  p_sk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sk_out);

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(busy_set));

  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);

  p_irq_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done_evt));

  p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_err && !shift_evt) |=> $stable(data_rdata));
endmodule

bind sio_port sio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .busy_set(busy_set),
  .sk_out(sk_out), .done_evt(done_evt), .irq(irq), .load_err(load_err),
  .shift_evt(shift_evt), .data_rdata(data_rdata)
);

// File: tb/tb_sio_port.sv
module tb_sio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [5:0] ctl_rdata;
  logic       busy_set = 1'b0, busy_clr = 1'b0, busy;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = '0, data_rdata;
  logic       load_err, irq;
  logic       sk_in = 1'b0, sk_out, si = 1'b0, so;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sio_port dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .busy_set(busy_set), .busy_clr(busy_clr),
    .busy(busy), .data_we(data_we), .data_wdata(data_wdata),
    .data_rdata(data_rdata), .load_err(load_err), .irq(irq),
    .sk_in(sk_in), .sk_out(sk_out), .si(si), .so(so)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic pulse_set();
    @(negedge clk); busy_set = 1'b1;
    @(negedge clk); busy_set = 1'b0;
  endtask

  // Expected register after k bits: loaded byte moved up, partner bits below
  function automatic logic [7:0] after_k(input logic [7:0] tx, input logic [7:0] pt, input int k);
    logic [15:0] w;
    w = {tx, pt} << k;
    return w[15:8];
  endfunction

  task automatic run_master(input logic [7:0] tx, input logic [7:0] pt, input bit alt,
                            input int rate, input bit ie, input int stop_k);
    logic [7:0] got;
    int nr, nf, cyc, last_r, irqs, perr, guard;
    logic prev;
    wr_ctl({ie, alt, 2'(rate), 1'b1, 1'b1});
    load(tx);
    si = alt ? 1'b0 : pt[7];
    pulse_set();
    got = '0; nr = 0; nf = 0; cyc = 0; last_r = 0; irqs = 0; perr = 0; guard = 0;
    prev = 1'b0;
    while (busy && guard < 1000) begin
      @(negedge clk); cyc++; guard++;
      if (irq) irqs++;
      if (sk_out && !prev) begin
        nr++;
        if (nr > 1 && (cyc - last_r) != (2 << rate)) perr++;
        last_r = cyc;
        if (!alt) got = {got[6:0], so};
        else if (nr <= 8) si = pt[8-nr];
      end else if (!sk_out && prev) begin
        nf++;
        if (!alt) begin
          if (nf < 8) si = pt[7-nf];
        end else got = {got[6:0], so};
        if (nf == stop_k && stop_k < 8) begin
          busy_clr = 1'b1;
          @(negedge clk); busy_clr = 1'b0;
          if (irq) irqs++;
          break;
        end
      end
      prev = sk_out;
    end
    if (stop_k >= 8) begin
      chk("R4 busy cleared", busy, 0);
      chk("R4 eight clock cycles", nf, 8);
      chk("R4 received byte", data_rdata, pt);
      chk(alt ? "R6 alternate phase output order" : "R5 normal phase output order", got, tx);
      chk("R3 shift clock period", perr, 0);
      chk("R8 interrupt count", irqs, ie ? 1 : 0);
      chk("R11 clock low after done", sk_out, 0);
    end else begin
      chk("R7 partial register", data_rdata, after_k(tx, pt, stop_k));
      chk("R7 busy dropped", busy, 0);
      chk("R7 no interrupt", irqs, 0);
      repeat (20) @(negedge clk);
      chk("R7 clock parked low", sk_out, 0);
      chk("R7 register held", data_rdata, after_k(tx, pt, stop_k));
    end
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] pt, input bit alt);
    logic [7:0] got;
    int skbad, irqs;
    wr_ctl({1'b1, alt, 2'b00, 1'b0, 1'b1});
    load(tx);
    pulse_set();
    got = '0; skbad = 0; irqs = 0;
    for (int i = 0; i < 8; i++) begin
      if (!alt) begin
        si = pt[7-i];
        repeat (6) @(negedge clk);
        got = {got[6:0], so};
        sk_in = 1'b1;
        repeat (6) begin @(negedge clk); if (sk_out) skbad++; if (irq) irqs++; end
        sk_in = 1'b0;
        repeat (6) begin @(negedge clk); if (sk_out) skbad++; if (irq) irqs++; end
      end else begin
        sk_in = 1'b1;
        repeat (6) begin @(negedge clk); if (sk_out) skbad++; if (irq) irqs++; end
        got = {got[6:0], so};
        si = pt[7-i];
        repeat (6) begin @(negedge clk); if (sk_out) skbad++; if (irq) irqs++; end
        sk_in = 1'b0;
        repeat (6) begin @(negedge clk); if (sk_out) skbad++; if (irq) irqs++; end
      end
    end
    chk("R9 slave busy cleared", busy, 0);
    chk("R9 slave received byte", data_rdata, pt);
    chk("R9 slave output order", got, tx);
    chk("R9 sk_out low in slave mode", skbad, 0);
    chk("R9 R8 slave interrupt", irqs, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 control clear at reset", ctl_rdata, 0);
    chk("R11 busy clear at reset", busy, 0);
    chk("R11 clock low at reset", sk_out, 0);
    chk("R1 data clear at reset", data_rdata, 0);
    chk("R8 irq low at reset", irq, 0);

    wr_ctl(6'h2D);
    chk("R1 control readback", ctl_rdata, 6'h2D);

    // R2 start ignored while disabled
    wr_ctl(6'h02);
    pulse_set();
    chk("R2 busy stays low when disabled", busy, 0);
    repeat (4) @(negedge clk);
    chk("R2 no clock when disabled", sk_out, 0);

    // Sweep rates, phases, interrupt enable and patterns
    for (int rate = 0; rate < 4; rate++)
      for (int alt = 0; alt < 2; alt++)
        for (int j = 0; j < 3; j++) begin
          logic [7:0] tx, pt;
          tx = 8'(8'h3C + j * 8'h59 + rate * 17 + alt * 5);
          pt = ~tx ^ 8'(j * 8'h33 + 8'h0F);
          run_master(tx, pt, alt[0], rate, j[0], 8);
        end

    // R7 early stop at every point, both phases
    for (int k = 1; k < 8; k++) begin
      run_master(8'hC3 ^ 8'(k * 9), 8'h5A + 8'(k), 1'b0, 0, 1'b1, k);
      run_master(8'h96 + 8'(k), 8'h27 ^ 8'(k * 21), 1'b1, 1, 1'b1, k);
    end

    // R9 slave mode, both phases
    run_slave(8'hB4, 8'h6D, 1'b0);
    run_slave(8'h1E, 8'hF0, 1'b1);
    run_slave(8'h81, 8'h7E, 1'b1);

    // R10 load while the slave clock is high
    wr_ctl(6'h01);
    load(8'h55);
    sk_in = 1'b1;
    repeat (6) @(negedge clk);
    data_we = 1'b1; data_wdata = 8'hAA;
    #1 chk("R10 load_err while clock high", load_err, 1);
    @(negedge clk); data_we = 1'b0;
    chk("R10 load ignored while clock high", data_rdata, 8'h55);
    sk_in = 1'b0;
    repeat (6) @(negedge clk);
    data_we = 1'b1; data_wdata = 8'hAA;
    #1 chk("R10 no load_err while clock low", load_err, 0);
    @(negedge clk); data_we = 1'b0;
    chk("R10 load accepted while clock low", data_rdata, 8'hAA);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule